// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block runs a serial EEPROM over four pins: a select line, a serial clock, a data line into the memory and a data line back from it. A host hands it one operation at a time: read a 16-bit word, write a 16-bit word, or probe the part to learn how wide its word address is. The controller builds each command frame, shifts it out, gathers returned data, and pulses `done` when the whole operation is over.

Every write is wrapped automatically. The controller sends a write-enable command, then the write frame with its data, then a ready poll that waits for the part to finish programming. The poll gives up after a set number of polls. Last comes a write-disable command. The probe reads word 0 with an 8-bit address. Its result chooses between 6-bit and 8-bit addressing for every later operation. A separate test input can start the fill-all or clear-all commands, and these are wrapped in the same way as a write. A divider parameter sets how many system clocks each half-period of the serial clock lasts.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: A frame is a 3-bit code followed by the word address, MSB first. The code is 110 for read, 101 for write and 100 for the extended group. The address is 6 bits in narrow mode and 8 bits in wide mode.
- R2: Each bit is put on `ee_di` while `ee_sk` is low, and then `ee_sk` is raised. `ee_sk` is low in the cycle before and the cycle after every change of `ee_cs`. `ee_sk` is high only while `ee_cs` is high. Each high phase of `ee_sk` lasts exactly DIV clocks.
- R3: A read sends the read frame and then gives 16 clock pulses. `ee_do` is sampled once per pulse, MSB first, and the 16-bit result appears on `rdata` together with `done`.
- R4: A write is four separate select periods in this order: write-enable (code 100, top two address bits 11, the rest 0); the write frame (code 101) followed by 16 data bits MSB first; a ready poll with no clock pulses; write-disable (code 100, address all 0).
- R5: The poll ends on the first sample with `ee_do` = 1. If `ee_do` stays 0 for POLL_LIMIT samples, write-disable is still sent and `done` comes with `err` = 1. Otherwise `err` = 0.
- R6: A probe (`req_op` = 2) reads word 0 with an 8-bit address, whatever `req_addr` holds. `wide_addr` becomes 1 if the word is 0x8129 and 0 otherwise. Later frames use 8 or 6 address bits to match, so narrow mode sends only `req_addr[5:0]`.
- R7: While `busy` is high, host requests and test requests are ignored and leave no trace on the pins or in the results. `done` is high for exactly one cycle. `rdata`, `wide_addr` and `err` change only in the `done` cycle, except that `err` clears when a request is accepted.
- R8: A pulse on `tst_valid` while idle runs the write wrapper around a fill-all command (code 100, top address bits 01, followed by `req_wdata`) when `tst_erase` = 0, or around a clear-all command (code 100, top address bits 10, no data) when `tst_erase` = 1. Host operations never send these two commands.
- R9: During and right after reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `err` are 0, `rdata` is 0, and `wide_addr` is 0 (narrow mode).
- R10: `done` rises exactly DIV clocks after the last fall of `ee_cs` in an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request strobe; taken only while idle |
| req_op | input | 2 | 0 read, 1 write, 2 probe, 3 treated as read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data; also the data for fill-all |
| tst_valid | input | 1 | Test request strobe (fill-all or clear-all) |
| tst_erase | input | 1 | 1 selects clear-all, 0 selects fill-all |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready poll timed out in the last write |
| rdata | output | DW | Last word read |
| wide_addr | output | 1 | 1 selects 8-bit addressing, 0 selects 6-bit |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
Every serial step lasts exactly DIV clocks, so the due cycles are fixed. `done` is due DIV clocks after the final fall of `ee_cs`, and the bench times this gap on each operation. Each high phase of `ee_sk` must last exactly DIV clocks. `rdata`, `err` and `wide_addr` are read in the cycle where `done` is seen, and `done` must be low again one cycle later. The bench models the memory behaviourally at each falling clock edge. It records every select period as a frame and compares it, whole, with the frames expected from the requirements once the operation has finished.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
// Package: shared codes and state types for the serial EEPROM controller.
// Assumes a 3-bit command code whose leading bit is always 1.
package mw_pkg;
    localparam logic [2:0]  CMD_READ  = 3'b110;
    localparam logic [2:0]  CMD_WRITE = 3'b101;
    localparam logic [2:0]  CMD_EXT   = 3'b100;
    localparam logic [1:0]  EXT_WDIS  = 2'b00;
    localparam logic [1:0]  EXT_FILL  = 2'b01;
    localparam logic [1:0]  EXT_CLEAR = 2'b10;
    localparam logic [1:0]  EXT_WEN   = 2'b11;
    localparam logic [15:0] WIDE_SIG  = 16'h8129;

    typedef enum logic [3:0] {
        E_IDLE, E_CSLO, E_CSHI, E_OLO, E_OHI, E_GAP, E_IHI, E_ILO, E_POLL, E_END
    } eng_st_e;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_st_e;

    typedef enum logic [2:0] {J_READ, J_WRITE, J_PROBE, J_FILL, J_CLEAR} job_e;

    typedef enum logic [2:0] {K_RD, K_WEN, K_WR, K_POLL, K_WDIS, K_ALL} kind_e;
endpackage

// File: rtl/mw_tick.sv
`timescale 1ns/1ps
// Module: step timer. Raises tick on the last clock of every DIV-clock step.
// Assumes restart holds the count at zero so the first step is a full DIV long.
module mw_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    // Count clocks within the current step; wrap on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mw_engine.sv
`timescale 1ns/1ps
// Module: bit engine. Runs one select period: select low, select high, shift out
// out_len bits MSB first, optionally clock in RXW bits, or poll ee_do until it
// reads 1 or POLL_LIMIT samples pass, then drop select. Every state lasts one
// DIV-clock step. Assumes start is given only while idle.
module mw_engine
    import mw_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int POLL_LIMIT = 20000,
    parameter int FW         = 27,
    parameter int RXW        = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       poll_mode,
    input  logic                       rx_en,
    input  logic [$clog2(FW+1)-1:0]    out_len,
    input  logic [FW-1:0]              out_bits,
    input  logic                       ee_do,
    output logic                       fin,
    output logic                       timed_out,
    output logic [RXW-1:0]             rx_word,
    output logic                       ee_cs,
    output logic                       ee_sk,
    output logic                       ee_di
);
    localparam int LW = $clog2(FW + 1);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int IW = $clog2(RXW + 1);

    eng_st_e         state;
    logic            tick;
    logic [FW-1:0]   shreg;
    logic [LW-1:0]   left;
    logic [IW-1:0]   rx_left;
    logic [PW-1:0]   polls;
    logic            pmode;
    logic            rxen;

    mw_tick #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state == E_IDLE),
        .tick    (tick)
    );

    // Pin values follow the state alone.
    always_comb begin
        ee_cs = !(state inside {E_IDLE, E_CSLO, E_END});
        ee_sk = (state == E_OHI) || (state == E_IHI);
        ee_di = ((state == E_OLO) || (state == E_OHI)) && shreg[FW-1];
    end

    assign fin = (state == E_END) && tick;

    // Step through the select period, one state per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= E_IDLE;
            shreg     <= '0;
            left      <= '0;
            rx_left   <= '0;
            polls     <= '0;
            pmode     <= 1'b0;
            rxen      <= 1'b0;
            timed_out <= 1'b0;
            rx_word   <= '0;
        end else if (state == E_IDLE) begin
            if (start) begin
                state     <= E_CSLO;
                shreg     <= out_bits;
                left      <= out_len;
                pmode     <= poll_mode;
                rxen      <= rx_en;
                polls     <= '0;
                rx_left   <= IW'(RXW);
                timed_out <= 1'b0;
            end
        end else if (tick) begin
            case (state)
                E_CSLO: state <= E_CSHI;
                E_CSHI: begin
                    if (pmode)            state <= E_POLL;
                    else if (left != '0)  state <= E_OLO;
                    else                  state <= E_GAP;
                end
                E_OLO: state <= E_OHI;
                E_OHI: begin
                    shreg <= {shreg[FW-2:0], 1'b0};
                    left  <= left - 1'b1;
                    state <= (left == LW'(1)) ? E_GAP : E_OLO;
                end
                E_GAP: state <= rxen ? E_IHI : E_END;
                E_IHI: begin
                    rx_word <= {rx_word[RXW-2:0], ee_do};
                    rx_left <= rx_left - 1'b1;
                    state   <= E_ILO;
                end
                E_ILO: state <= (rx_left == '0) ? E_END : E_IHI;
                E_POLL: begin
                    if (ee_do) begin
                        state <= E_END;
                    end else if (polls == PW'(POLL_LIMIT - 1)) begin
                        timed_out <= 1'b1;
                        state     <= E_END;
                    end else begin
                        polls <= polls + 1'b1;
                    end
                end
                E_END:   state <= E_IDLE;
                default: state <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mw_seq.sv
`timescale 1ns/1ps
// Module: operation sequencer. Takes a host or test request, walks its list of
// select periods (read: one; write, fill, clear: enable, command, poll,
// disable), builds each frame in 6- or 8-bit address form and records the
// results. Assumes the engine raises fin once per started select period.
module mw_seq
    import mw_pkg::*;
#(
    parameter int AW  = 8,
    parameter int NAW = 6,
    parameter int DW  = 16,
    parameter int FW  = 3 + AW + DW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [1:0]              req_op,
    input  logic [AW-1:0]           req_addr,
    input  logic [DW-1:0]           req_wdata,
    input  logic                    tst_valid,
    input  logic                    tst_erase,
    input  logic                    eng_fin,
    input  logic                    eng_tmo,
    input  logic [DW-1:0]           eng_rx,
    output logic                    eng_start,
    output logic                    eng_poll,
    output logic                    eng_rx_en,
    output logic [$clog2(FW+1)-1:0] eng_len,
    output logic [FW-1:0]           eng_bits,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [DW-1:0]           rdata,
    output logic                    wide_addr
);
    localparam int LW = $clog2(FW + 1);

    seq_st_e        st;
    job_e           job;
    logic [1:0]     idx;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  data_q;
    logic           tmo_q;
    kind_e          kind;
    logic           last;
    logic           use_wide;
    logic [2:0]     code;
    logic [AW-1:0]  a_wide;
    logic [NAW-1:0] a_nar;
    logic [DW-1:0]  dat;
    logic           has_dat;

    // Pick the select period for this job and step index.
    always_comb begin
        kind = K_RD;
        last = 1'b1;
        if (job != J_READ && job != J_PROBE) begin
            last = (idx == 2'd3);
            case (idx)
                2'd0:    kind = K_WEN;
                2'd1:    kind = (job == J_WRITE) ? K_WR : K_ALL;
                2'd2:    kind = K_POLL;
                default: kind = K_WDIS;
            endcase
        end
    end

    // Build the frame fields for the current select period.
    always_comb begin
        code    = CMD_EXT;
        a_wide  = '0;
        a_nar   = '0;
        dat     = '0;
        has_dat = 1'b0;
        case (kind)
            K_RD: begin
                code   = CMD_READ;
                a_wide = addr_q;
                a_nar  = addr_q[NAW-1:0];
            end
            K_WR: begin
                code    = CMD_WRITE;
                a_wide  = addr_q;
                a_nar   = addr_q[NAW-1:0];
                dat     = data_q;
                has_dat = 1'b1;
            end
            K_WEN: begin
                a_wide = {EXT_WEN, {(AW-2){1'b0}}};
                a_nar  = {EXT_WEN, {(NAW-2){1'b0}}};
            end
            K_ALL: begin
                if (job == J_FILL) begin
                    a_wide  = {EXT_FILL, {(AW-2){1'b0}}};
                    a_nar   = {EXT_FILL, {(NAW-2){1'b0}}};
                    dat     = data_q;
                    has_dat = 1'b1;
                end else begin
                    a_wide = {EXT_CLEAR, {(AW-2){1'b0}}};
                    a_nar  = {EXT_CLEAR, {(NAW-2){1'b0}}};
                end
            end
            default: begin
                a_wide = '0;
                a_nar  = '0;
            end
        endcase
    end

    // Assemble the left-aligned frame and its length for the engine.
    always_comb begin
        use_wide  = (job == J_PROBE) || wide_addr;
        eng_poll  = (kind == K_POLL);
        eng_rx_en = (kind == K_RD);
        if (eng_poll) begin
            eng_bits = '0;
            eng_len  = '0;
        end else if (use_wide) begin
            eng_bits = {code, a_wide, dat};
            eng_len  = LW'(3 + AW) + (has_dat ? LW'(DW) : LW'(0));
        end else begin
            eng_bits = {code, a_nar, dat, {(AW-NAW){1'b0}}};
            eng_len  = LW'(3 + NAW) + (has_dat ? LW'(DW) : LW'(0));
        end
    end

    assign eng_start = (st == S_ISSUE);
    assign busy      = (st != S_IDLE);

    // Accept requests, step through the list, record the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            job       <= J_READ;
            idx       <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            tmo_q     <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            rdata     <= '0;
            wide_addr <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        case (req_op)
                            2'd1:    job <= J_WRITE;
                            2'd2:    job <= J_PROBE;
                            default: job <= J_READ;
                        endcase
                        addr_q <= (req_op == 2'd2) ? '0 : req_addr;
                        data_q <= req_wdata;
                        idx    <= '0;
                        tmo_q  <= 1'b0;
                        err    <= 1'b0;
                        st     <= S_ISSUE;
                    end else if (tst_valid) begin
                        job    <= tst_erase ? J_CLEAR : J_FILL;
                        addr_q <= '0;
                        data_q <= req_wdata;
                        idx    <= '0;
                        tmo_q  <= 1'b0;
                        err    <= 1'b0;
                        st     <= S_ISSUE;
                    end
                end
                S_ISSUE: st <= S_WAIT;
                S_WAIT: begin
                    if (eng_fin) begin
                        if (kind == K_POLL) tmo_q <= eng_tmo;
                        if (last) begin
                            st   <= S_IDLE;
                            done <= 1'b1;
                            err  <= tmo_q;
                            if (job == J_READ || job == J_PROBE) rdata <= eng_rx;
                            if (job == J_PROBE) wide_addr <= (eng_rx == DW'(WIDE_SIG));
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= S_ISSUE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
`timescale 1ns/1ps
// Module: top of the serial EEPROM controller. Joins the sequencer, which
// decides what to send, with the bit engine, which drives the pins.
// Assumes ee_do is already synchronous to clk.
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int POLL_LIMIT = 20000,
    parameter int AW         = 8,
    parameter int NAW        = 6,
    parameter int DW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          tst_valid,
    input  logic          tst_erase,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic          wide_addr,
    output logic          ee_cs,
    output logic          ee_sk,
    output logic          ee_di,
    input  logic          ee_do
);
    localparam int FW = 3 + AW + DW;
    localparam int LW = $clog2(FW + 1);

    logic          eng_start;
    logic          eng_poll;
    logic          eng_rx_en;
    logic [LW-1:0] eng_len;
    logic [FW-1:0] eng_bits;
    logic          eng_fin;
    logic          eng_tmo;
    logic [DW-1:0] eng_rx;

    mw_seq #(.AW(AW), .NAW(NAW), .DW(DW), .FW(FW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .tst_valid (tst_valid),
        .tst_erase (tst_erase),
        .eng_fin   (eng_fin),
        .eng_tmo   (eng_tmo),
        .eng_rx    (eng_rx),
        .eng_start (eng_start),
        .eng_poll  (eng_poll),
        .eng_rx_en (eng_rx_en),
        .eng_len   (eng_len),
        .eng_bits  (eng_bits),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .wide_addr (wide_addr)
    );

    mw_engine #(.DIV(DIV), .POLL_LIMIT(POLL_LIMIT), .FW(FW), .RXW(DW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .poll_mode (eng_poll),
        .rx_en     (eng_rx_en),
        .out_len   (eng_len),
        .out_bits  (eng_bits),
        .ee_do     (ee_do),
        .fin       (eng_fin),
        .timed_out (eng_tmo),
        .rx_word   (eng_rx),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di)
    );
endmodule

// File: rtl/mw_eeprom_chk.sv
`timescale 1ns/1ps
// Module: property checker for the serial EEPROM controller, bound to the top.
// Assumes synchronous active-low reset.
module mw_eeprom_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] rdata,
    input logic          wide_addr,
    input logic          ee_cs,
    input logic          ee_sk,
    input logic          ee_di
);
    AST_CS_EDGE_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_cs) |-> (!ee_sk && !$past(ee_sk)));                 // R2
    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);                                                // R2
    AST_DI_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_di);                                              // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                 // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !ee_cs));                                     // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rdata) && $stable(wide_addr)));               // R7
endmodule

bind mw_eeprom_ctrl mw_eeprom_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .wide_addr (wide_addr),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di)
);

// File: tb/mw_eeprom_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural EEPROM model, frame recorder, per-clock pin checks.
module mw_eeprom_ctrl_tb_top;
    localparam int DIV  = 2;
    localparam int PL   = 40;
    localparam int BUSY = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_addr = 8'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        tst_valid = 1'b0;
    logic        tst_erase = 1'b0;
    logic        busy, done, err, wide_addr, ee_cs, ee_sk, ee_di;
    logic [15:0] rdata;
    logic        ee_do = 1'b0;

    mw_eeprom_ctrl #(.DIV(DIV), .POLL_LIMIT(PL)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .tst_valid(tst_valid),
        .tst_erase(tst_erase), .busy(busy), .done(done), .err(err),
        .rdata(rdata), .wide_addr(wide_addr), .ee_cs(ee_cs), .ee_sk(ee_sk),
        .ee_di(ee_di), .ee_do(ee_do)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- EEPROM model and pin monitor ----------------
    logic [15:0] mem [256];
    int          m_aw = 6;
    bit          wen = 0, stuck = 0, pend = 0, rd_act = 0, prog = 0;
    int          busy_cnt = 0, fnb = 0, f_op = 0, f_addr = 0, f_sub = 0, ridx = 0;
    logic [63:0] fbits = '0;
    logic [15:0] rword = '0;
    logic        p_cs = 0, p_sk = 0;
    int          cyc = 0, fall_cyc = 0, rise_cyc = 0;
    logic [63:0] got_b[$], exp_b[$];
    int          got_n[$], exp_n[$];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ee_cs !== p_cs)
                chk(!ee_sk && !p_sk, "R2 sk low at cs change", {ee_sk, p_sk}, 0);
            if (ee_sk && !p_sk) rise_cyc = cyc;
            if (!ee_sk && p_sk)
                chk(cyc - rise_cyc == DIV, "R2 sk high length", cyc - rise_cyc, DIV);
            if (done)
                chk(cyc - fall_cyc == DIV, "R10 done after cs fall", cyc - fall_cyc, DIV);
            if (ee_cs && !p_cs) begin
                fnb = 0; fbits = '0; pend = 0; rd_act = 0;
            end
            if (ee_cs && ee_sk && !p_sk) begin
                fbits = {fbits[62:0], ee_di};
                fnb++;
                if (fnb == 3 + m_aw) begin
                    f_op   = int'((fbits >> m_aw) & 64'd7);
                    f_addr = int'(fbits & ((64'd1 << m_aw) - 1));
                    f_sub  = f_addr >> (m_aw - 2);
                    if (f_op == 6) pend = 1;
                    if (f_op == 4 && f_sub == 3) wen = 1;
                    if (f_op == 4 && f_sub == 0) wen = 0;
                    if (f_op == 4 && f_sub == 2 && wen) begin
                        foreach (mem[i]) mem[i] = 16'hFFFF;
                        prog = 1;
                    end
                end
                if (fnb == 3 + m_aw + 16 && wen) begin
                    if (f_op == 5) begin mem[f_addr] = fbits[15:0]; prog = 1; end
                    if (f_op == 4 && f_sub == 1) begin
                        foreach (mem[i]) mem[i] = fbits[15:0];
                        prog = 1;
                    end
                end
            end
            if (ee_cs && !ee_sk && p_sk) begin
                if (pend) begin pend = 0; rd_act = 1; rword = mem[f_addr]; ridx = 15; end
                else if (rd_act && ridx > 0) ridx--;
            end
            if (busy_cnt > 0) busy_cnt--;
            if (!ee_cs && p_cs) begin
                got_b.push_back(fbits);
                got_n.push_back(fnb);
                fall_cyc = cyc;
                if (prog) busy_cnt = BUSY;
                prog = 0; rd_act = 0; pend = 0;
            end
        end
        ee_do = rd_act ? rword[ridx] : (ee_cs && busy_cnt == 0 && !stuck);
        p_cs = ee_cs;
        p_sk = ee_sk;
    end

    // ---------------- expectation helpers ----------------
    task automatic push_exp(input int op, input int a, input int aw, input bit has,
                            input int d);
        logic [63:0] v;
        int nb;
        v  = (64'(op) << aw) | 64'(a);
        nb = 3 + aw;
        if (has) begin v = (v << 16) | 64'(d & 16'hFFFF); nb += 16; end
        exp_b.push_back(v);
        exp_n.push_back(nb);
    endtask

    task automatic push_poll();
        exp_b.push_back('0);
        exp_n.push_back(0);
    endtask

    task automatic exp_wrap(input int op, input int a, input bit has, input int d,
                            input int aw);
        push_exp(4, 3 << (aw - 2), aw, 0, 0);
        push_exp(op, a, aw, has, d);
        push_poll();
        push_exp(4, 0, aw, 0, 0);
    endtask

    task automatic cmp_frames(input string req);
        chk(got_n.size() == exp_n.size(), {req, " frame count"}, got_n.size(), exp_n.size());
        while (got_n.size() > 0 && exp_n.size() > 0) begin
            int gn, en;
            logic [63:0] gb, eb;
            gn = got_n.pop_front(); en = exp_n.pop_front();
            gb = got_b.pop_front(); eb = exp_b.pop_front();
            chk(gn == en, {req, " frame length"}, gn, en);
            chk(gb == eb, {req, " frame bits"}, gb, eb);
        end
        got_n.delete(); got_b.delete(); exp_n.delete(); exp_b.delete();
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done, {req, " done seen"}, done, 1);
        @(negedge clk);
        chk(!done, "R7 done is one cycle", done, 0);
    endtask

    task automatic host(input int op, input int a, input int d);
        @(negedge clk);
        req_valid = 1; req_op = 2'(op); req_addr = 8'(a); req_wdata = 16'(d);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic host_done(input int op, input int a, input int d, input string req);
        host(op, a, d);
        wait_done(req);
    endtask

    // done and results are read in the negedge where done is seen
    task automatic read_chk(input int a, input int aw, input logic [15:0] e,
                            input string req);
        push_exp(6, a, aw, 1, 0);
        host(0, a, 0);
        while (!done) @(negedge clk);
        chk(rdata == e, {req, " rdata"}, rdata, e);
        chk(err == 0, "R7 err clear after read", err, 0);
        @(negedge clk);
        cmp_frames(req);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'hA5C3;
        mem[0] = 16'h1234;
        repeat (4) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done, err} == 0, "R9 reset pins",
            {ee_cs, ee_sk, ee_di, busy, done, err}, 0);
        chk(rdata == 0 && wide_addr == 0, "R9 reset results", {rdata, wide_addr}, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(!busy && !ee_cs && !wide_addr, "R9 after reset", {busy, ee_cs, wide_addr}, 0);

        // R3 / R1: narrow read
        read_chk(5, 6, mem[5], "R3 narrow read");
        // R4: narrow write then read back
        exp_wrap(5, 42, 1, 16'hBEEF, 6);
        host_done(1, 42, 16'hBEEF, "R4 narrow write");
        chk(err == 0, "R5 err low when ready", err, 0);
        cmp_frames("R4 narrow write");
        chk(mem[42] == 16'hBEEF, "R4 word programmed", mem[42], 16'hBEEF);
        read_chk(42, 6, 16'hBEEF, "R3 read back");

        // R6: probe, word 0 not the signature
        m_aw = 8;
        push_exp(6, 0, 8, 1, 0);
        host(2, 8'h55, 0);
        while (!done) @(negedge clk);
        chk(rdata == 16'h1234, "R6 probe data", rdata, 16'h1234);
        chk(wide_addr == 0, "R6 narrow chosen", wide_addr, 0);
        @(negedge clk);
        cmp_frames("R6 probe");
        m_aw = 6;
        read_chk(8'h7F & 8'h3F, 6, mem[8'h3F], "R6 narrow address");

        // R6: probe with signature
        mem[0] = 16'h8129;
        m_aw = 8;
        push_exp(6, 0, 8, 1, 0);
        host_done(2, 0, 0, "R6 probe wide");
        chk(wide_addr == 1, "R6 wide chosen", wide_addr, 1);
        cmp_frames("R6 probe wide");
        read_chk(8'hC3, 8, mem[8'hC3], "R1 wide read");
        exp_wrap(5, 8'h81, 1, 16'h1357, 8);
        host_done(1, 8'h81, 16'h1357, "R4 wide write");
        cmp_frames("R4 wide write");
        chk(mem[8'h81] == 16'h1357, "R4 wide word programmed", mem[8'h81], 16'h1357);

        // R7: requests while busy are ignored
        begin
            logic [15:0] keep;
            keep = mem[8'h10];
            push_exp(6, 8'h10, 8, 1, 0);
            host(0, 8'h10, 0);
            @(negedge clk);
            req_valid = 1; req_op = 2'd1; req_addr = 8'h10; req_wdata = 16'h0000;
            tst_valid = 1; tst_erase = 1;
            repeat (6) @(negedge clk);
            req_valid = 0; tst_valid = 0;
            while (!done) @(negedge clk);
            chk(rdata == keep, "R7 read result unchanged", rdata, keep);
            @(negedge clk);
            repeat (4) @(negedge clk);
            chk(!busy, "R7 no extra operation", busy, 0);
            cmp_frames("R7 busy ignore");
            chk(mem[8'h10] == keep, "R7 memory untouched", mem[8'h10], keep);
        end

        // R5: poll timeout
        stuck = 1;
        exp_wrap(5, 8'h22, 1, 16'h4444, 8);
        host(1, 8'h22, 16'h4444);
        while (!done) @(negedge clk);
        chk(err == 1, "R5 timeout flag", err, 1);
        @(negedge clk);
        cmp_frames("R5 timeout still disables");
        stuck = 0;
        repeat (BUSY) @(negedge clk);
        read_chk(8'h22, 8, 16'h4444, "R7 err cleared next");

        // R8: fill-all and clear-all via the test input
        exp_wrap(4, 1 << 6, 1, 16'h0F0F, 8);
        @(negedge clk);
        tst_valid = 1; tst_erase = 0; req_wdata = 16'h0F0F;
        @(negedge clk);
        tst_valid = 0;
        wait_done("R8 fill");
        cmp_frames("R8 fill");
        read_chk(7, 8, 16'h0F0F, "R8 fill result");
        exp_wrap(4, 2 << 6, 0, 0, 8);
        @(negedge clk);
        tst_valid = 1; tst_erase = 1;
        @(negedge clk);
        tst_valid = 0;
        wait_done("R8 clear");
        cmp_frames("R8 clear");
        read_chk(8'h99, 8, 16'hFFFF, "R8 clear result");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule